// File: doc/BRIEF.md
# Bit Scan and Population Count Unit

This unit evaluates one 16-bit source word with one of three operations: a scan for the lowest set bit, a scan for the highest set bit, or a count of the set bits. A caller presents the source and an operation code and raises a start strobe for one cycle. On the next clock edge the unit registers four things: the 16-bit result, a write-enable for the destination register, a done pulse and a six-bit arithmetic flag set.

The two scans have no index to give when the source is zero. In that case the unit raises the zero flag, keeps the destination write-enable low and leaves the result and every other flag as they were. The count always produces a value, so it always writes. Between strobes all outputs hold. Decode, register file and memory operand handling sit outside the unit.

Top module: `bsp_unit`

## Requirements
- R1: With op_i = 2'b00 and a non-zero source, the registered result is the zero-extended index (0..15) of the lowest set bit of the source.
- R2: With op_i = 2'b01 and a non-zero source, the registered result is the zero-extended index (0..15) of the highest set bit of the source.
- R3: A scan (op_i[1] = 0) of a zero source sets ZF (flags_o[3]) to 1, keeps wr_en_o low, and leaves result_o and flags_o bits 5, 4, 2, 1 and 0 at their previous values.
- R4: A scan of a non-zero source writes the result with ZF = 0, OF (bit 5), SF (bit 4), AF (bit 2) and CF (bit 0) all 0, and PF (bit 1) = 1 exactly when the low byte of the index has an even number of ones.
- R5: A count (op_i[1] = 1, so both 2'b10 and 2'b11) always writes the number of set bits of the source (0..16), zero-extended, with wr_en_o high.
- R6: After a count, ZF is 1 exactly when the count is 0, and OF, SF, AF, PF and CF are all 0.
- R7: done_o is high in exactly the cycle after each cycle in which start_i is sampled high, and wr_en_o is high only in such a cycle.
- R8: In a cycle after start_i is sampled low, result_o and flags_o keep their values and done_o and wr_en_o are low.
- R9: While rst_n is low, result_o and flags_o are 0 and done_o and wr_en_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that launches an operation |
| op_i | input | 2 | Operation: 00 lowest-bit scan, 01 highest-bit scan, 1x set-bit count |
| src_i | input | 16 | Source operand |
| result_o | output | 16 | Registered result |
| wr_en_o | output | 1 | Destination write-enable, pulsed with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| flags_o | output | 6 | Flags {OF, SF, ZF, AF, PF, CF}, bit 5 down to bit 0 |

## Verification
Sources with a single set bit at each end of the word separate the two scan directions from each other and from off-by-one index errors, while an all-ones word gives the two scans opposite answers and the count its maximum of 16. Zero sources are given to both scans right after an operation that left PF set, so a design that clears or rewrites the kept flags, or overwrites the result, is exposed, and a zero count shows that the count still writes and raises ZF. Random words, biased towards zero and one-hot values, are mixed across all four operation codes to cover parity of the index and the alias code 2'b11, and each strobe is followed by an idle cycle to check the hold behaviour.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  typedef enum logic [1:0] {
    OP_SCAN_LO  = 2'b00,
    OP_SCAN_HI  = 2'b01,
    OP_COUNT    = 2'b10,
    OP_COUNT_B  = 2'b11
  } op_e;

  // Packed so that the first member lands on bit 5.
  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } flags_t;

  // Parity flag convention: high when the byte has an even number of ones.
  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/bsp_scan.sv
module bsp_scan #(
  parameter int DATA_W  = 16,
  parameter bit REVERSE = 1'b0,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  output logic [IDX_W-1:0]  idx,
  output logic              any_set
);

  function automatic logic [IDX_W-1:0] lowest_one(input logic [DATA_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = DATA_W - 1; k >= 0; k--) begin
      if (v[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] highest_one(input logic [DATA_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (v[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  assign any_set = |src;

  generate
    if (REVERSE) begin : g_high
      assign idx = highest_one(src);
      // Nothing above the reported index may be set (R2).
      always_comb begin
        if (any_set) begin
          p_nothing_above_r2 : assert ((src >> idx) == {{(DATA_W-1){1'b0}}, 1'b1});
        end
      end
    end else begin : g_low
      assign idx = lowest_one(src);
      // Nothing below the reported index may be set (R1).
      always_comb begin
        if (any_set) begin
          p_nothing_below_r1 : assert (((src << (DATA_W - 1 - int'(idx))) & {DATA_W{1'b1}}) ==
                                       {1'b1, {(DATA_W-1){1'b0}}});
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bsp_popcount.sv
module bsp_popcount #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] src,
  output logic [CNT_W-1:0]  count
);

  logic [CNT_W-1:0] partial [DATA_W+1];

  assign partial[0] = '0;

  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_acc
      assign partial[g+1] = partial[g] + CNT_W'(src[g]);
    end
  endgenerate

  assign count = partial[DATA_W];

  // A zero count and a non-zero source never go together (R6).
  always_comb begin
    p_zero_count_zero_src_r6 : assert ((count == '0) == (src == '0));
  end

endmodule

// File: rtl/bsp_flag_calc.sv
module bsp_flag_calc
  import bsp_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  op_e               op,
  input  logic [IDX_W-1:0]  lo_idx,
  input  logic [IDX_W-1:0]  hi_idx,
  input  logic              any_set,
  input  logic [CNT_W-1:0]  count,
  input  flags_t            prev_flags,
  output logic [DATA_W-1:0] next_result,
  output flags_t            next_flags,
  output logic              write
);

  function automatic flags_t logic_flags(input logic [DATA_W-1:0] r);
    flags_t f;
    f.of_f = 1'b0;
    f.sf_f = r[DATA_W-1];
    f.zf_f = 1'b0;
    f.af_f = 1'b0;
    f.pf_f = even_ones8(r[7:0]);
    f.cf_f = 1'b0;
    return f;
  endfunction

  function automatic flags_t count_flags(input logic [CNT_W-1:0] c);
    flags_t f;
    f      = '0;
    f.zf_f = (c == '0);
    return f;
  endfunction

  logic [DATA_W-1:0] scan_value;

  always_comb begin
    scan_value = (op == OP_SCAN_HI) ? DATA_W'(hi_idx) : DATA_W'(lo_idx);
    next_result = '0;
    next_flags  = prev_flags;
    write       = 1'b0;
    unique case (op)
      OP_SCAN_LO, OP_SCAN_HI: begin
        if (any_set) begin
          next_result = scan_value;
          next_flags  = logic_flags(scan_value);
          write       = 1'b1;
        end else begin
          next_flags.zf_f = 1'b1;
        end
      end
      OP_COUNT, OP_COUNT_B: begin
        next_result = DATA_W'(count);
        next_flags  = count_flags(count);
        write       = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bsp_unit.sv
module bsp_unit
  import bsp_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int FLG_W = $bits(flags_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              done_o,
  output logic [FLG_W-1:0]  flags_o
);

  op_e               op;
  logic [IDX_W-1:0]  lo_idx;
  logic [IDX_W-1:0]  hi_idx;
  logic              lo_any;
  logic              hi_any;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] next_result;
  flags_t            next_flags;
  logic              next_write;

  logic [DATA_W-1:0] result_q;
  flags_t            flags_q;
  logic              done_q;
  logic              wr_q;

  // Named events for the checks below.
  logic scan_req;
  logic zero_scan_evt;
  logic count_evt;

  assign op            = op_e'(op_i);
  assign scan_req      = start_i && !op_i[1];
  assign zero_scan_evt = scan_req && (src_i == '0);
  assign count_evt     = start_i && op_i[1];

  bsp_scan #(.DATA_W(DATA_W), .REVERSE(1'b0)) i_scan_lo (
    .src     (src_i),
    .idx     (lo_idx),
    .any_set (lo_any)
  );

  bsp_scan #(.DATA_W(DATA_W), .REVERSE(1'b1)) i_scan_hi (
    .src     (src_i),
    .idx     (hi_idx),
    .any_set (hi_any)
  );

  bsp_popcount #(.DATA_W(DATA_W)) i_count (
    .src   (src_i),
    .count (count)
  );

  bsp_flag_calc #(.DATA_W(DATA_W)) i_flags (
    .op          (op),
    .lo_idx      (lo_idx),
    .hi_idx      (hi_idx),
    .any_set     (lo_any),
    .count       (count),
    .prev_flags  (flags_q),
    .next_result (next_result),
    .next_flags  (next_flags),
    .write       (next_write)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      flags_q  <= '0;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
    end else if (start_i) begin
      done_q  <= 1'b1;
      wr_q    <= next_write;
      flags_q <= next_flags;
      if (next_write) result_q <= next_result;
    end else begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
    end
  end

  assign result_o = result_q;
  assign flags_o  = flags_q;
  assign done_o   = done_q;
  assign wr_en_o  = wr_q;

  // Both scanners must agree on whether any bit is set.
  p_scanners_agree_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    lo_any == hi_any);

  p_done_after_start_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  p_write_needs_done_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o);

  p_idle_holds_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o && !wr_en_o && $stable(result_o) && $stable(flags_o));

  p_zero_scan_no_write_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    zero_scan_evt |=> !wr_en_o && flags_q.zf_f && $stable(result_o)
                      && $stable({flags_q.of_f, flags_q.sf_f, flags_q.af_f,
                                  flags_q.pf_f, flags_q.cf_f}));

  p_live_scan_flags_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    scan_req && (src_i != '0) |=> wr_en_o && !flags_q.zf_f && !flags_q.of_f
                                  && !flags_q.cf_f && !flags_q.af_f);

  p_count_writes_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    count_evt |=> wr_en_o && (result_o <= DATA_W'(DATA_W)));

  p_count_flags_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    count_evt |=> !flags_q.of_f && !flags_q.sf_f && !flags_q.af_f
                  && !flags_q.pf_f && !flags_q.cf_f);

endmodule

// File: tb/test_bsp_unit.sv
module test_bsp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [15:0] src_i = 16'h0000;
  logic [15:0] result_o;
  logic        wr_en_o;
  logic        done_o;
  logic [5:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] exp_result = 16'h0000;
  logic [5:0]  exp_flags  = 6'b000000;

  always #4 clk = ~clk;

  bsp_unit i_bsp_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .src_i    (src_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .done_o   (done_o),
    .flags_o  (flags_o)
  );

  function automatic int ref_low(input logic [15:0] v);
    int i = 0;
    while (v[0] == 1'b0) begin v = v >> 1; i++; end
    return i;
  endfunction

  function automatic int ref_high(input logic [15:0] v);
    int i = 15;
    while (v[15] == 1'b0) begin v = v << 1; i--; end
    return i;
  endfunction

  function automatic int ref_ones(input logic [15:0] v);
    int n = 0;
    foreach (v[b]) if (v[b]) n++;
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Drives one strobe, checks the registered outputs, then one idle cycle.
  task automatic run_op(input logic [1:0] op, input logic [15:0] src);
    logic exp_wr;
    int   v;
    @(negedge clk);
    start_i = 1'b1; op_i = op; src_i = src;
    if (op[1]) begin
      v = ref_ones(src);
      exp_wr = 1'b1;
      exp_result = 16'(v);
      exp_flags = (v == 0) ? 6'b001000 : 6'b000000;
    end else if (src == 16'h0000) begin
      exp_wr = 1'b0;
      exp_flags[3] = 1'b1;
    end else begin
      v = op[0] ? ref_high(src) : ref_low(src);
      exp_wr = 1'b1;
      exp_result = 16'(v);
      exp_flags = {4'b0000, (ref_ones(16'(v & 8'hFF)) % 2 == 0), 1'b0};
    end
    @(negedge clk);
    start_i = 1'b0;
    check("R7 done after strobe", 32'(done_o), 32'd1);
    if (op[1]) begin
      check("R5 count result", 32'(result_o), 32'(exp_result));
      check("R5 count write", 32'(wr_en_o), 32'd1);
      check("R6 count flags", 32'(flags_o), 32'(exp_flags));
    end else if (src == 16'h0000) begin
      check("R3 zero scan no write", 32'(wr_en_o), 32'd0);
      check("R3 zero scan result kept", 32'(result_o), 32'(exp_result));
      check("R3 zero scan flags", 32'(flags_o), 32'(exp_flags));
    end else begin
      check(op[0] ? "R2 highest index" : "R1 lowest index", 32'(result_o), 32'(exp_result));
      check("R4 scan write", 32'(wr_en_o), 32'(exp_wr));
      check("R4 scan flags", 32'(flags_o), 32'(exp_flags));
    end
    src_i = ~src;
    op_i = ~op;
    @(negedge clk);
    check("R8 done low when idle", 32'(done_o), 32'd0);
    check("R8 write low when idle", 32'(wr_en_o), 32'd0);
    check("R8 result held", 32'(result_o), 32'(exp_result));
    check("R8 flags held", 32'(flags_o), 32'(exp_flags));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] s;
    logic [1:0]  o;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 reset result", 32'(result_o), 32'd0);
    check("R9 reset flags", 32'(flags_o), 32'd0);
    check("R9 reset done", 32'(done_o), 32'd0);
    check("R9 reset write", 32'(wr_en_o), 32'd0);
    rst_n = 1'b1;

    run_op(2'b00, 16'h8000);   // R1 top bit only
    run_op(2'b00, 16'h0001);   // R1 bottom bit
    run_op(2'b01, 16'h0001);   // R2 bottom bit
    run_op(2'b01, 16'hFFFF);   // R2 all ones
    run_op(2'b00, 16'hFFF8);   // R1 index 3, PF set (R4)
    run_op(2'b00, 16'h0000);   // R3 keeps PF, sets ZF
    run_op(2'b01, 16'h0000);   // R3 reverse
    run_op(2'b10, 16'h0000);   // R5/R6 zero count writes
    run_op(2'b10, 16'hFFFF);   // R5 max count
    run_op(2'b11, 16'h00F0);   // R5 alias code
    run_op(2'b01, 16'h0000);   // R3 after count

    for (int n = 0; n < 400; n++) begin
      case ($urandom % 4)
        0: s = 16'h0000;
        1: s = 16'h0001 << ($urandom % 16);
        default: s = 16'($urandom);
      endcase
      o = 2'($urandom);
      run_op(o, s);
    end
    finish_run();
  end

endmodule